// File: doc/BRIEF.md
# UART Transmit Path with Buffered Holding Stage

This block is the sending half of a serial port. A host pushes bytes through a simple write strobe into a holding stage. That stage is either a 64-entry first-in first-out buffer or, with buffering turned off, a single-byte holding slot. A small state machine takes the oldest byte from the holding stage, loads it into a shift register and sends it on the serial line. A frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts 16 or 8 pulses of an external oversampling tick. When idle, the line rests high.

The block drives two status flags. One shows that the holding stage is empty and the other that the shifter is empty. It raises a transmit interrupt when occupancy falls to below a programmable threshold and again when the stage runs dry. In half-duplex direction mode the interrupt is instead raised when the final stop bit has left the line. With automatic clear-to-send gating on, a new character is started only while the active-low clear-to-send input is asserted. The input is looked at only between characters.

The state machine has four states. IDLE moves to START when data is queued and sending is permitted; that cycle pops the holding stage and loads the shifter. START moves to DATA at the end of the start bit. DATA stays in DATA at the end of each of the first seven data bits and moves to STOP at the end of the eighth. STOP moves back to IDLE at the end of the stop bit. Every bit ends on the baud tick that completes its 16 or 8 tick count.

Top module: `uart_tx_path`

## Requirements
- R1: Each character goes out as one low start bit, then 8 data bits starting with bit 0, then one high stop bit. The line is high whenever no character is in the shifter.
- R2: A bit lasts 16 baud ticks when `os8_mode` is 0 and 8 baud ticks when it is 1. With a tick on every clock, the start bit is exactly 16 or 8 clocks wide.
- R3: The holding stage takes 64 bytes when `fifo_en` is 1 and one byte when it is 0. A write while the stage is at capacity is dropped, even if a pop happens in the same cycle, and it sets `overflow`, which stays set until reset.
- R4: `thr_empty` is 1 exactly when the holding stage contains no bytes.
- R5: `tsr_empty` is 0 from the cycle after a byte is taken into the shifter until its stop bit has ended. Otherwise it is 1.
- R6: With `fifo_en`=1 and `half_duplex_en`=0, a pending interrupt flag is set by a pop whose pre-pop occupancy equals `trig_level` or equals 1. A `trig_level` of 0 leaves only the empty event. An accepted write clears the flag, and a set in the same cycle wins.
- R7: With `fifo_en`=0 and `half_duplex_en`=0, the pending flag is set each time the holding byte moves into the shifter, while that character is still being sent.
- R8: With `half_duplex_en`=1, pops never set the pending flag. It is set only when a stop bit ends while the holding stage is empty.
- R9: `tx_irq` is the pending flag gated by `tx_irq_en`. Enabling raises `tx_irq` at once if an event is still pending.
- R10: With `cts_auto_en`=1 and `cts_n`=1, no new character starts. A character already started always completes. With `cts_auto_en`=0, `cts_n` has no effect.
- R11: After reset `tx_out`=1, `thr_empty`=1, `tsr_empty`=1, `tx_irq`=0 and `overflow`=0.
- R12: Bytes leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling tick, one clock wide |
| os8_mode | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| fifo_en | input | 1 | 1: 64-byte buffer, 0: single holding byte |
| cts_auto_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low |
| half_duplex_en | input | 1 | Interrupt source becomes shifter empty |
| tx_irq_en | input | 1 | Interrupt output enable |
| trig_level | input | 7 | Occupancy threshold for the interrupt |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| tx_out | output | 1 | Serial line |
| thr_empty | output | 1 | Holding stage empty |
| tsr_empty | output | 1 | Shifter empty |
| tx_irq | output | 1 | Transmit interrupt |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The checker assumes that `fifo_en` only changes while the holding stage is empty. This keeps the fill-bound and drop-on-full properties consistent with the current capacity. The stimulus changes mode inputs only after the line and holding stage have both gone idle. It also assumes that `baud_tick` is a single-cycle pulse. The bench drives it from a divider that changes period only between vector runs. Clear-to-send and the interrupt controls are changed on the falling clock edge, so every change is seen by one whole rising edge.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              wr_accept,
    output logic              overflow
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nx, rd_nx;
    logic [CNT_W-1:0]  cap;
    logic              full, rd_ok;

    assign cap       = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
    assign full      = (count >= cap);
    assign wr_accept = wr_en && !full;
    assign rd_ok     = rd_en && (count != '0);
    assign rd_data   = mem[rd_ptr];

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
            assign wr_nx = wr_ptr + PTR_W'(1);
            assign rd_nx = rd_ptr + PTR_W'(1);
        end else begin : g_wrap_cmp
            assign wr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            assign rd_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_accept) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (wr_accept) begin
                wr_ptr <= wr_nx;
            end
            if (rd_ok) begin
                rd_ptr <= rd_nx;
            end
            unique case ({wr_accept, rd_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
            if (wr_en && full) begin
                overflow <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk #(
    parameter int OS_HI = 16,
    parameter int OS_LO = 8,
    localparam int OS_W = $clog2(OS_HI)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic os8_mode,
    input  logic run,
    output logic bit_end
);
    logic [OS_W-1:0] tick_cnt;
    logic [OS_W-1:0] last_tick;

    assign last_tick = os8_mode ? OS_W'(OS_LO - 1) : OS_W'(OS_HI - 1);
    assign bit_end   = run && baud_tick && (tick_cnt >= last_tick);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (!run) begin
            tick_cnt <= '0;
        end else if (baud_tick) begin
            tick_cnt <= (tick_cnt >= last_tick) ? '0 : tick_cnt + OS_W'(1);
        end
    end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_end,
    input  logic              have_data,
    input  logic              send_ok,
    input  logic [DATA_W-1:0] load_data,
    output logic              pop,
    output logic              tx_line,
    output logic              shifter_idle,
    output logic              frame_done
);
    tx_state_e         state, state_nx;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
        end else begin
            if (pop) begin
                shreg <= load_data;
            end else if (state == ST_DATA && bit_end) begin
                shreg <= shreg >> 1;
            end
            if (state == ST_START) begin
                bit_idx <= '0;
            end else if (state == ST_DATA && bit_end) begin
                bit_idx <= bit_idx + IDX_W'(1);
            end
        end
    end

    always_comb begin
        state_nx     = state;
        pop          = 1'b0;
        frame_done   = 1'b0;
        tx_line      = 1'b1;
        shifter_idle = 1'b0;
        unique case (state)
            ST_IDLE: begin
                shifter_idle = 1'b1;
                if (have_data && send_ok) begin
                    pop      = 1'b1;
                    state_nx = ST_START;
                end
            end
            ST_START: begin
                tx_line = 1'b0;
                if (bit_end) begin
                    state_nx = ST_DATA;
                end
            end
            ST_DATA: begin
                tx_line = shreg[0];
                if (bit_end && bit_idx == IDX_W'(DATA_W - 1)) begin
                    state_nx = ST_STOP;
                end
            end
            ST_STOP: begin
                if (bit_end) begin
                    frame_done = 1'b1;
                    state_nx   = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] trig_level,
    input  logic             fifo_mode,
    input  logic             half_duplex,
    input  logic             frame_done,
    input  logic             wr_accept,
    input  logic             irq_en,
    output logic             irq
);
    logic pending, set_evt, hold_evt, shift_evt;

    assign hold_evt  = pop && (!fifo_mode || fill == CNT_W'(1) || fill == trig_level);
    assign shift_evt = frame_done && (fill == '0);
    assign set_evt   = half_duplex ? shift_evt : hold_evt;
    assign irq       = pending && irq_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (set_evt) begin
            pending <= 1'b1;
        end else if (wr_accept) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int OS_HI  = 16,
    parameter int OS_LO  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              os8_mode,
    input  logic              fifo_en,
    input  logic              cts_auto_en,
    input  logic              cts_n,
    input  logic              half_duplex_en,
    input  logic              tx_irq_en,
    input  logic [CNT_W-1:0]  trig_level,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_out,
    output logic              thr_empty,
    output logic              tsr_empty,
    output logic              tx_irq,
    output logic              overflow
);
    logic [DATA_W-1:0] head_data;
    logic [CNT_W-1:0]  fifo_count;
    logic              wr_accept, pop, bit_end, frame_done, send_ok;

    assign send_ok   = !cts_auto_en || !cts_n;
    assign thr_empty = (fifo_count == '0);

    uart_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (fifo_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (pop),
        .rd_data   (head_data),
        .count     (fifo_count),
        .wr_accept (wr_accept),
        .overflow  (overflow)
    );

    uart_tx_bitclk #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .os8_mode  (os8_mode),
        .run       (!tsr_empty),
        .bit_end   (bit_end)
    );

    uart_tx_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_end      (bit_end),
        .have_data    (!thr_empty),
        .send_ok      (send_ok),
        .load_data    (head_data),
        .pop          (pop),
        .tx_line      (tx_out),
        .shifter_idle (tsr_empty),
        .frame_done   (frame_done)
    );

    uart_tx_irq #(.CNT_W(CNT_W)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop         (pop),
        .fill        (fifo_count),
        .trig_level  (trig_level),
        .fifo_mode   (fifo_en),
        .half_duplex (half_duplex_en),
        .frame_done  (frame_done),
        .wr_accept   (wr_accept),
        .irq_en      (tx_irq_en),
        .irq         (tx_irq)
    );
endmodule

// File: rtl/uart_tx_path_chk.sv
module uart_tx_path_chk #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             wr_en,
    input logic             cts_auto_en,
    input logic             cts_n,
    input logic             tx_out,
    input logic             tsr_empty,
    input logic             overflow,
    input logic [CNT_W-1:0] fill
);
    logic [CNT_W-1:0] cap;
    assign cap = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);

    p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= cap);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fill == cap) |=> overflow);

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tsr_empty |-> tx_out);

    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_out) |-> !tsr_empty);

    p_cts_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_auto_en && cts_n && tsr_empty) |=> tsr_empty);
endmodule

bind uart_tx_path uart_tx_path_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .wr_en       (wr_en),
    .cts_auto_en (cts_auto_en),
    .cts_n       (cts_n),
    .tx_out      (tx_out),
    .tsr_empty   (tsr_empty),
    .overflow    (overflow),
    .fill        (fifo_count)
);

// File: tb/uart_tx_path_bench.sv
`timescale 1ns/1ps
module uart_tx_path_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       os8_mode = 1'b0, fifo_en = 1'b1, cts_auto_en = 1'b0, cts_n = 1'b1;
    logic       half_duplex_en = 1'b0, tx_irq_en = 1'b0, wr_en = 1'b0;
    logic [6:0] trig_level = '0;
    logic [7:0] wr_data = '0;
    logic       tx_out, thr_empty, tsr_empty, tx_irq, overflow;

    always #4 clk = ~clk;

    uart_tx_path u_uart_tx_path (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .os8_mode(os8_mode),
        .fifo_en(fifo_en), .cts_auto_en(cts_auto_en), .cts_n(cts_n),
        .half_duplex_en(half_duplex_en), .tx_irq_en(tx_irq_en),
        .trig_level(trig_level), .wr_en(wr_en), .wr_data(wr_data),
        .tx_out(tx_out), .thr_empty(thr_empty), .tsr_empty(tsr_empty),
        .tx_irq(tx_irq), .overflow(overflow)
    );

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // baud tick divider
    int tick_div = 1, tick_cnt = 0, bits_per = 16;
    always @(negedge clk) begin
        if (tick_cnt >= tick_div - 1) begin
            baud_tick = 1'b1;
            tick_cnt  = 0;
        end else begin
            baud_tick = 1'b0;
            tick_cnt++;
        end
    end

    // line decoder
    logic [7:0] rx_buf [0:127];
    int  rx_n = 0, rx_starts = 0, frame_err = 0, last_width = 0, dec_cnt = 0;
    bit  dec_busy = 0, width_done = 0;
    logic [7:0] dec_sh = '0;
    logic prev_line = 1'b1;
    always @(negedge clk) begin
        int len, half, j;
        len  = bits_per * tick_div;
        half = len / 2;
        if (dec_busy) begin
            dec_cnt++;
            if (!width_done && tx_out) begin
                last_width = dec_cnt;
                width_done = 1;
            end
            if (dec_cnt >= half && ((dec_cnt - half) % len) == 0) begin
                j = (dec_cnt - half) / len;
                if (j == 0) begin
                    if (tx_out) frame_err++;
                end else if (j <= 8) begin
                    dec_sh = {tx_out, dec_sh[7:1]};
                end else begin
                    if (!tx_out) frame_err++;
                    if (rx_n < 128) rx_buf[rx_n] = dec_sh;
                    rx_n++;
                    dec_busy = 0;
                end
            end
        end else if (prev_line && !tx_out) begin
            dec_busy   = 1;
            dec_cnt    = 0;
            width_done = 0;
            rx_starts++;
        end
        prev_line = tx_out;
    end

    task automatic rx_clear();
        rx_n = 0; rx_starts = 0; frame_err = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (!(thr_empty && tsr_empty)) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_irq_rise(output int starts);
        while (!tx_irq) @(negedge clk);
        #1;
        starts = rx_starts;
    endtask

    // {fifo, os8, div[1:0], count[6:0], base[7:0], start width[7:0]}
    localparam logic [26:0] VEC [0:5] = '{
        {1'b1, 1'b0, 2'd1, 7'd3,  8'hA5, 8'd16},
        {1'b1, 1'b1, 2'd1, 7'd5,  8'h33, 8'd8},
        {1'b0, 1'b0, 2'd1, 7'd2,  8'h01, 8'd16},
        {1'b0, 1'b1, 2'd2, 7'd2,  8'hFF, 8'd16},
        {1'b1, 1'b0, 2'd3, 7'd2,  8'h5B, 8'd48},
        {1'b1, 1'b1, 2'd1, 7'd20, 8'h11, 8'd8}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int s, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(tx_out == 1'b1,    "R11 tx_out",    tx_out, 1);
        chk(thr_empty == 1'b1, "R11 thr_empty", thr_empty, 1);
        chk(tsr_empty == 1'b1, "R11 tsr_empty", tsr_empty, 1);
        chk(tx_irq == 1'b0,    "R11 tx_irq",    tx_irq, 0);
        chk(overflow == 1'b0,  "R11 overflow",  overflow, 0);

        // vector table; cts_n stays high with gating off (R10 ignored case)
        for (int v = 0; v < 6; v++) begin
            logic [26:0] e;
            int n;
            e        = VEC[v];
            fifo_en  = e[26];
            os8_mode = e[25];
            tick_div = int'(e[24:23]);
            bits_per = e[25] ? 8 : 16;
            n        = int'(e[22:16]);
            repeat (8) @(negedge clk);
            rx_clear();
            for (int i = 0; i < n; i++) begin
                if (!fifo_en) while (!thr_empty) @(negedge clk);
                write_byte(e[15:8] + 8'(2 * i));
            end
            wait_idle();
            chk(rx_n == n, "R12 R10 frame count", rx_n, n);
            bad = 0;
            for (int i = 0; i < n && i < 128; i++)
                if (rx_buf[i] !== e[15:8] + 8'(2 * i)) bad++;
            chk(bad == 0, "R1 data bits", bad, 0);
            chk(frame_err == 0, "R1 start/stop levels", frame_err, 0);
            chk(last_width <= int'(e[7:0]) && last_width > int'(e[7:0]) - tick_div,
                "R2 start bit width", last_width, int'(e[7:0]));
        end
        tick_div = 1;

        // R3 / R12: FIFO capacity and drop on full
        do_reset();
        fifo_en = 1; os8_mode = 1; bits_per = 8; cts_auto_en = 1; cts_n = 1;
        rx_clear();
        for (int i = 0; i < 64; i++) write_byte(8'(i));
        chk(overflow == 1'b0, "R3 no overflow at 64", overflow, 0);
        chk(thr_empty == 1'b0, "R4 thr_empty with data", thr_empty, 0);
        write_byte(8'hEE);
        chk(overflow == 1'b1, "R3 overflow on 65th", overflow, 1);
        cts_n = 0;
        wait_idle();
        chk(overflow == 1'b1, "R3 overflow sticky", overflow, 1);
        chk(rx_n == 64, "R3 byte count", rx_n, 64);
        bad = 0;
        for (int i = 0; i < 64; i++) if (rx_buf[i] !== 8'(i)) bad++;
        chk(bad == 0, "R12 order", bad, 0);

        // R3 holding-register capacity
        do_reset();
        fifo_en = 0; cts_n = 1;
        rx_clear();
        write_byte(8'h3C);
        chk(overflow == 1'b0, "R3 single slot ok", overflow, 0);
        write_byte(8'hC3);
        chk(overflow == 1'b1, "R3 single slot drop", overflow, 1);
        cts_n = 0;
        wait_idle();
        chk(rx_n == 1 && rx_buf[0] == 8'h3C, "R3 kept byte", int'(rx_buf[0]), 'h3C);

        // R10 / R5 clear-to-send gating
        do_reset();
        fifo_en = 1; cts_n = 1;
        rx_clear();
        write_byte(8'h81);
        write_byte(8'h7E);
        repeat (200) @(negedge clk);
        chk(tx_out == 1'b1 && rx_starts == 0, "R10 held off", rx_starts, 0);
        chk(tsr_empty == 1'b1, "R5 idle shifter", tsr_empty, 1);
        chk(thr_empty == 1'b0, "R4 queued", thr_empty, 0);
        cts_n = 0;
        while (tsr_empty) @(negedge clk);
        cts_n = 1;
        chk(tsr_empty == 1'b0, "R5 busy shifter", tsr_empty, 0);
        while (!tsr_empty) @(negedge clk);
        repeat (200) @(negedge clk);
        chk(rx_n == 1 && rx_buf[0] == 8'h81 && frame_err == 0,
            "R10 started char completes", int'(rx_buf[0]), 'h81);
        chk(rx_starts == 1 && thr_empty == 1'b0, "R10 second held", rx_starts, 1);
        cts_n = 0;
        wait_idle();
        chk(rx_n == 2 && rx_buf[1] == 8'h7E, "R10 resumes", int'(rx_buf[1]), 'h7E);

        // R6 FIFO trigger and empty interrupts
        do_reset();
        fifo_en = 1; tx_irq_en = 1; trig_level = 7'd4; cts_n = 1;
        for (int i = 0; i < 6; i++) write_byte(8'h51 + 8'(i));
        chk(tx_irq == 1'b0, "R6 no irq before pops", tx_irq, 0);
        rx_clear();
        cts_n = 0;
        wait_irq_rise(s);
        chk(s == 3, "R6 trigger crossing", s, 3);
        trig_level = 7'd0;
        write_byte(8'h99);
        chk(tx_irq == 1'b0, "R6 cleared by write", tx_irq, 1'b0);
        wait_irq_rise(s);
        chk(s == 7, "R6 empty event", s, 7);
        chk(tsr_empty == 1'b0, "R6 fires before shifter drains", tsr_empty, 0);
        wait_idle();

        // R8 half-duplex source
        do_reset();
        fifo_en = 1; half_duplex_en = 1; tx_irq_en = 1; trig_level = 7'd2; cts_auto_en = 0;
        rx_clear();
        for (int i = 0; i < 3; i++) write_byte(8'hC1 + 8'(i));
        wait_irq_rise(s);
        chk(s == 3 && rx_n == 3, "R8 fires after last stop", rx_n, 3);
        chk(tsr_empty == 1'b1, "R8 shifter empty at irq", tsr_empty, 1);
        wait_idle();

        // R9 gating and R7 holding-register source
        do_reset();
        fifo_en = 0; half_duplex_en = 0; tx_irq_en = 0;
        rx_clear();
        write_byte(8'h42);
        repeat (3) @(negedge clk);
        chk(tx_irq == 1'b0, "R9 masked", tx_irq, 0);
        tx_irq_en = 1;
        @(negedge clk);
        chk(tx_irq == 1'b1, "R9 pending kept", tx_irq, 1);
        wait_idle();
        write_byte(8'h24);
        chk(tx_irq == 1'b0, "R7 cleared by write", tx_irq, 0);
        wait_irq_rise(s);
        chk(s == 2 && tsr_empty == 1'b0, "R7 fires on transfer", s, 2);
        wait_idle();
        chk(rx_n == 2 && rx_buf[1] == 8'h24, "R7 byte sent", int'(rx_buf[1]), 'h24);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule